// File: doc/BRIEF.md
# Repeated-Addition Sequential Multiplier

This block forms the unsigned product of two words. It adds one operand into an accumulator once per clock, as many times as the other operand says, and does not shift. A single-cycle start strobe, accepted only while the unit is idle, captures both operands. The first operand (the count) sets the number of additions. The second operand (the addend) is added to an accumulator that starts from zero. After each addition the count goes down by one. When the count is zero, the accumulator is copied to the product output and a one-cycle done pulse is raised.

The multiplier suits places where area matters more than time and the count operand is known to be small. The time to a result grows linearly with the count. The product holds the low `WIDTH` bits of the true product, so every sum wraps. The product output keeps its value until the next operation completes.

Top module: `rep_add_mult`

## Requirements
- R1: After reset, `busyOut` and `doneOut` are 0 and `prodOut` is 0.
- R2: A `startIn` pulse seen at a rising edge while `busyOut` is 0 latches `opCount` and `opAddend`, and `busyOut` is 1 from the next cycle.
- R3: `prodOut` after completion equals (count × addend) mod 2^WIDTH, with every addition wrapping.
- R4: For a start accepted at edge k, `doneOut` is 1 in exactly the cycle after edge k+count+1. The count goes down by exactly one on each addition.
- R5: A count of zero gives a product of 0 and a done pulse after edge k+1, with no addition made.
- R6: `doneOut` lasts one cycle, and `busyOut` is 0 while `doneOut` is 1.
- R7: While `busyOut` is 1, `startIn` and any change of `opCount` or `opAddend` are ignored. The result is that of the originally latched operands, and no extra done pulse follows.
- R8: `prodOut` changes only at a completion and holds its value between completions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| startIn | input | 1 | Start strobe, taken only when idle |
| opCount | input | WIDTH | Operand that sets the number of additions |
| opAddend | input | WIDTH | Operand added on each step |
| busyOut | output | 1 | High while an operation is in progress |
| doneOut | output | 1 | One-cycle pulse when the product is valid |
| prodOut | output | WIDTH | Low WIDTH bits of the product, held |

## Verification
The multiplier is driven with small counts and ordinary addends, with a zero count, and with a count of zero paired with a nonzero addend. These show whether the step loop runs the right number of times and whether the zero path skips it. Addends near 2^32 with small counts check that sums wrap to the low bits and do not saturate. A long count of one thousand checks that latency tracks the operand value. A start, with changed operands, sent in the middle of an operation must change neither the product nor the number of done pulses. Back-to-back starts issued the cycle busy falls, and idle gaps after a completion, show that the product output holds between results.

// File: rtl/rep_mul_pkg.sv
`timescale 1ns/1ps
package rep_mul_pkg;
  // Strobes from the controller to the datapath
  typedef struct packed {
    logic load;    // capture operands, clear accumulator
    logic step;    // decrement count, add addend
    logic finish;  // publish accumulator as product
  } mulCtrl_t;
endpackage

// File: rtl/rep_mul_ctrl.sv
`timescale 1ns/1ps
module rep_mul_ctrl
  import rep_mul_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     startIn,
  input  logic     countZero,
  output mulCtrl_t ctrl,
  output logic     busyOut,
  output logic     doneOut
);
  logic busyReg;
  logic doneReg;

  always_comb begin
    ctrl.load   = startIn && !busyReg;
    ctrl.step   = busyReg && !countZero;
    ctrl.finish = busyReg && countZero;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyReg <= 1'b0;
      doneReg <= 1'b0;
    end else begin
      doneReg <= ctrl.finish;
      if (ctrl.load)
        busyReg <= 1'b1;
      else if (ctrl.finish)
        busyReg <= 1'b0;
    end
  end

  assign busyOut = busyReg;
  assign doneOut = doneReg;

  AST_BUSY_ON_START: assert property (@(posedge clk) disable iff (!rstN)
    (startIn && !busyOut) |=> busyOut); // R2
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |=> !doneOut); // R6
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |-> !busyOut); // R6
  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (busyOut && startIn && !countZero) |=> busyOut && !doneOut); // R7
endmodule

// File: rtl/rep_mul_dp.sv
`timescale 1ns/1ps
module rep_mul_dp
  import rep_mul_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  mulCtrl_t         ctrl,
  input  logic [WIDTH-1:0] opCount,
  input  logic [WIDTH-1:0] opAddend,
  output logic             countZero,
  output logic [WIDTH-1:0] prodOut
);
  localparam logic [WIDTH-1:0] ONE  = WIDTH'(1);
  localparam logic [WIDTH-1:0] ZERO = '0;

  logic [WIDTH-1:0] countReg;
  logic [WIDTH-1:0] addendReg;
  logic [WIDTH-1:0] accReg;
  logic [WIDTH-1:0] prodReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countReg  <= ZERO;
      addendReg <= ZERO;
      accReg    <= ZERO;
    end else if (ctrl.load) begin
      countReg  <= opCount;
      addendReg <= opAddend;
      accReg    <= ZERO;
    end else if (ctrl.step) begin
      countReg  <= countReg - ONE;
      accReg    <= accReg + addendReg;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      prodReg <= ZERO;
    else if (ctrl.finish)
      prodReg <= accReg;
  end

  assign countZero = (countReg == ZERO);
  assign prodOut   = prodReg;

  AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.step |=> countReg == $past(countReg) - ONE); // R4
  AST_ADDEND_HELD: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.step |=> $stable(addendReg)); // R7
  AST_PROD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.finish |=> $stable(prodOut)); // R8
  AST_ZERO_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.load && opCount == ZERO) |=> ##1 prodOut == ZERO); // R5
endmodule

// File: rtl/rep_add_mult.sv
`timescale 1ns/1ps
module rep_add_mult
  import rep_mul_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startIn,
  input  logic [WIDTH-1:0] opCount,
  input  logic [WIDTH-1:0] opAddend,
  output logic             busyOut,
  output logic             doneOut,
  output logic [WIDTH-1:0] prodOut
);
  mulCtrl_t ctrlBus;
  logic     countZero;

  rep_mul_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .startIn   (startIn),
    .countZero (countZero),
    .ctrl      (ctrlBus),
    .busyOut   (busyOut),
    .doneOut   (doneOut)
  );

  rep_mul_dp #(.WIDTH(WIDTH)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrlBus),
    .opCount   (opCount),
    .opAddend  (opAddend),
    .countZero (countZero),
    .prodOut   (prodOut)
  );
endmodule

// File: tb/rep_add_mult_tb.sv
`timescale 1ns/1ps
module rep_add_mult_tb;
  localparam int W = 32;

  typedef struct {
    logic [W-1:0] expProd;
    int           expCycle;
    int           tag;
  } item_t;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         startIn = 1'b0;
  logic [W-1:0] opCount = '0;
  logic [W-1:0] opAddend = '0;
  logic         busyOut, doneOut;
  logic [W-1:0] prodOut;

  int checks = 0;
  int fails = 0;
  int cycle = 0;
  int doneSeen = 0;
  item_t sb[$];

  rep_add_mult #(.WIDTH(W)) u_dut (
    .clk(clk), .rstN(rstN), .startIn(startIn), .opCount(opCount),
    .opAddend(opAddend), .busyOut(busyOut), .doneOut(doneOut), .prodOut(prodOut)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cycle <= cycle + 1;

  task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Driver: waits for idle, pushes expectation, pulses start
  task automatic doMul(input logic [W-1:0] m, input logic [W-1:0] n);
    item_t it;
    @(negedge clk);
    while (busyOut) @(negedge clk);
    it.expProd  = m * n;                 // R3: low W bits
    it.expCycle = cycle + int'(m) + 2;   // R4: start edge + count + 1
    it.tag      = (m == 0) ? 5 : 3;
    sb.push_back(it);
    opCount  = m;
    opAddend = n;
    startIn  = 1'b1;
    @(negedge clk);
    startIn  = 1'b0;
    checks++;                            // R2
    if (!busyOut) begin
      fails++;
      $display("FAIL R2 actual busy=%0d expected=1", busyOut);
    end
  endtask

  // Monitor: pops and compares on each done pulse
  logic prevDone = 1'b0;
  always @(negedge clk) begin
    if (rstN) begin
      if (doneOut) begin
        doneSeen++;
        check(!prevDone, "R6 pulse width", {31'b0, prevDone}, '0);
        check(!busyOut, "R6 busy low at done", {31'b0, busyOut}, '0);
        if (sb.size() == 0) begin
          check(1'b0, "R7 unexpected done", prodOut, '0);
        end else begin
          item_t it;
          it = sb.pop_front();
          check(prodOut == it.expProd, (it.tag == 5) ? "R5 product" : "R3 product",
                prodOut, it.expProd);
          check(cycle == it.expCycle, (it.tag == 5) ? "R5 latency" : "R4 latency",
                W'(cycle), W'(it.expCycle));
        end
      end
      prevDone = doneOut;
    end
  end

  initial begin
    logic [W-1:0] held;
    #1;
    check(!busyOut && !doneOut && prodOut == '0, "R1 reset",
          {prodOut[W-3:0], busyOut, doneOut}, '0);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(!busyOut && !doneOut && prodOut == '0, "R1 after release",
          prodOut, '0);

    doMul(32'd4, 32'd6);
    doMul(32'd0, 32'd77);                // R5
    doMul(32'd1, 32'd0);
    doMul(32'd3, 32'hFFFF_FFFF);         // R3 wrap
    doMul(32'd2, 32'h8000_0000);         // R3 wrap to zero
    doMul(32'd1000, 32'd12345);          // R4 long
    doMul(32'd0, 32'd0);

    // R7: start with new operands while busy
    doMul(32'd5, 32'd7);
    @(negedge clk);
    opCount = 32'd1; opAddend = 32'd99; startIn = 1'b1;
    @(negedge clk);
    startIn = 1'b0;
    opAddend = 32'd1234;
    while (busyOut) @(negedge clk);
    @(negedge clk);
    check(sb.size() == 0, "R7 no extra job", W'(sb.size()), '0);

    // R8: product holds across idle cycles
    held = prodOut;
    opCount = 32'd9; opAddend = 32'd9;
    repeat (10) @(negedge clk);
    check(prodOut == held, "R8 hold", prodOut, held);
    check(held == 32'd35, "R7 result of first operands", held, 32'd35);

    doMul(32'd7, 32'd13);
    repeat (12) @(negedge clk);
    check(sb.size() == 0, "R3 queue drained", W'(sb.size()), '0);
    check(doneSeen == 9, "R6 done count", W'(doneSeen), 32'd9);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(5 * 100000);
    fails++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule